// File: doc/BRIEF.md
# Peripheral Bridge Access Gate

The gate sits where a multi-master system bus hands accesses to a simple peripheral bus. Each access that arrives carries the requesting master's identifier, the bus privilege attribute, a flag saying whether the master is trusted, and the index of the peripheral slot it targets. The gate either forwards the access downstream, with a supervisor signal that it computes, or ends it with a two-cycle error response. When it ends an access this way, no downstream transfer starts.

The gate is configured through its own small register file, reached by the same request port with `req_to_regs` set. One privilege word holds a 4-bit control field for each master. Bit 0 of a master's field decides whether that master's privilege attribute reaches the peripherals, or whether the master is always demoted to user mode. Five lock words hold a 4-bit field for each of 34 peripheral slots. Bit 0 of a slot's field shuts that slot to untrusted masters. Every register resets to zero. Out of reset, every master is therefore demoted and every slot is open.

Top module: `periph_gate`

## Requirements
- R1: After reset, all configuration words read zero, `req_ready` is 1, and `resp_err`, `resp_ok` and `pbus_start` are 0.
- R2: On a forwarded access from a master whose field bit 0 is 0, `pbus_super` is 0 whatever `req_prot1` is.
- R3: On a forwarded access from a master whose field bit 0 is 1, `pbus_super` equals that access's `req_prot1`.
- R4: An access with `req_trusted`=0 to a slot whose field bit 0 is 1 ends in the error sequence, and `pbus_start` stays 0 throughout.
- R5: A peripheral access that R4 does not block raises `pbus_start` for one cycle, in the cycle after acceptance, with `pbus_slot` equal to the requested slot.
- R6: The error sequence occupies the two cycles after acceptance. In the first, `resp_err`=1 and `req_ready`=0. In the second, `resp_err`=1 and `req_ready`=1. After that, `resp_err` drops unless a new failing access was accepted in the second cycle.
- R7: A register access with `req_prot1`=0 ends in the error sequence, and a write made this way leaves every register unchanged.
- R8: Word 0 (byte offset 0x00) holds master m's field in bits [31-4m:28-4m]. Slot k's field lies in word 16+k/8 (byte offsets 0x40 to 0x50), in bits [31-4(k mod 8):28-4(k mod 8)]. A register read returns the word on `resp_rdata` with `resp_ok`=1 in the cycle after acceptance. A write returns `resp_rdata`=0.
- R9: The following read as zero and ignore writes: master 4's field (bits 15:12 of word 0), bits 7:0 of word 0, bits 23:0 of word 20, and every other word index.
- R10: Bits 3:1 of every implemented field are stored and read back, but they have no effect on forcing or gating.
- R11: Master IDs 4, 6 and 7 are always demoted to user mode. Slot indices 34 to 63 are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| req_valid | input | 1 | Access request present |
| req_to_regs | input | 1 | Access targets the gate's own registers |
| req_write | input | 1 | 1 = write, 0 = read |
| req_master | input | 3 | Requesting master ID |
| req_prot1 | input | 1 | Privileged-access attribute of the request |
| req_trusted | input | 1 | Requesting master is trusted |
| req_slot | input | 6 | Target peripheral slot |
| req_word | input | 5 | Register word index (byte offset / 4) |
| req_wdata | input | 32 | Register write data |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| resp_err | output | 1 | Error response active |
| resp_ok | output | 1 | Register access completed |
| resp_rdata | output | 32 | Register read data |
| pbus_start | output | 1 | Downstream transfer start pulse |
| pbus_super | output | 1 | Supervisor attribute of the downstream transfer |
| pbus_slot | output | 6 | Slot of the downstream transfer |

## Verification
The hardest state to reach from the ports is an untrusted access to a locked slot. Setting the lock takes a privileged register write first, while every master is demoted out of reset. A second hard case is a failing access accepted in the second error cycle, which must restart the sequence without a gap. The stimulus interleaves random privileged writes, many of which set bit 0 of lock and privilege fields, with random reads and random peripheral accesses across all master IDs and all 64 slot codes. A directed step issues two failing accesses back to back, so the second is accepted in the second error cycle. Directed writes of all-ones patterns expose the unimplemented bits.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int FIELD_W    = 4;
  localparam int WORD_BITS  = 32;
  localparam int FLD_PER_WD = WORD_BITS / FIELD_W;
  localparam int PRIV_WORD  = 0;
  localparam int LOCK_WORD0 = 16;

  typedef enum logic [1:0] {
    DEC_FWD,
    DEC_REG,
    DEC_ERR
  } gate_dec_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERR1,
    ST_ERR2
  } gate_st_e;
endpackage

// File: rtl/gate_cfg_regs.sv
module gate_cfg_regs
  import gate_pkg::*;
#(
  parameter int                   NUM_MASTERS = 6,
  parameter logic [NUM_MASTERS-1:0] MASTER_MAP = 6'b101111,
  parameter int                   NUM_SLOTS   = 34,
  parameter int                   WORD_W      = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [WORD_W-1:0]      word,
  input  logic [WORD_BITS-1:0]   wdata,
  output logic [WORD_BITS-1:0]   rdata,
  output logic [NUM_MASTERS-1:0] priv_en,
  output logic [NUM_SLOTS-1:0]   slot_lock
);
  localparam logic [WORD_W-1:0] PW = WORD_W'(PRIV_WORD);

  logic [FIELD_W-1:0] priv_q [NUM_MASTERS];
  logic [FIELD_W-1:0] lock_q [NUM_SLOTS];

  // Privilege fields: only present masters get storage
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    localparam int HI = WORD_BITS - 1 - FIELD_W * m;
    if (MASTER_MAP[m]) begin : g_store
      logic wr_en;
      assign wr_en = we && (word == PW);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     priv_q[m] <= '0;
        else if (wr_en) priv_q[m] <= wdata[HI -: FIELD_W];
      end
    end else begin : g_absent
      assign priv_q[m] = '0;
    end
    assign priv_en[m] = priv_q[m][0];
  end

  // Lock fields: slot k lives in word LOCK_WORD0 + k/8
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [WORD_W-1:0] SW = WORD_W'(LOCK_WORD0 + k / FLD_PER_WD);
    localparam int                HI = WORD_BITS - 1 - FIELD_W * (k % FLD_PER_WD);
    logic wr_en;
    assign wr_en = we && (word == SW);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lock_q[k] <= '0;
      else if (wr_en) lock_q[k] <= wdata[HI -: FIELD_W];
    end
    assign slot_lock[k] = lock_q[k][0];
  end

  always_comb begin
    rdata = '0;
    if (word == PW) begin
      for (int m = 0; m < NUM_MASTERS; m++)
        rdata[WORD_BITS-1-FIELD_W*m -: FIELD_W] = priv_q[m];
    end
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (word == WORD_W'(LOCK_WORD0 + k / FLD_PER_WD))
        rdata[WORD_BITS-1-FIELD_W*(k % FLD_PER_WD) -: FIELD_W] = lock_q[k];
    end
  end
endmodule

// File: rtl/gate_policy.sv
module gate_policy
  import gate_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_SLOTS   = 34,
  parameter int MID_W       = 3,
  parameter int SLOT_W      = 6
) (
  input  logic                   to_regs,
  input  logic [MID_W-1:0]       master,
  input  logic                   prot1,
  input  logic                   trusted,
  input  logic [SLOT_W-1:0]      slot,
  input  logic [NUM_MASTERS-1:0] priv_en,
  input  logic [NUM_SLOTS-1:0]   slot_lock,
  output gate_dec_e              dec,
  output logic                   super_o
);
  localparam int MPAD = 1 << MID_W;
  localparam int SPAD = 1 << SLOT_W;

  logic [MPAD-1:0] priv_pad;
  logic [SPAD-1:0] lock_pad;

  // IDs and slots beyond the implemented range see a zero field
  assign priv_pad = MPAD'(priv_en);
  assign lock_pad = SPAD'(slot_lock);

  assign super_o = prot1 & priv_pad[master];

  always_comb begin
    if (to_regs)                        dec = prot1 ? DEC_REG : DEC_ERR;
    else if (!trusted && lock_pad[slot]) dec = DEC_ERR;
    else                                dec = DEC_FWD;
  end
endmodule

// File: rtl/gate_resp.sv
module gate_resp
  import gate_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  gate_dec_e            dec,
  input  logic                 super_i,
  input  logic                 write,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [WORD_BITS-1:0] rdata_c,
  output logic                 ready,
  output logic                 resp_err,
  output logic                 resp_ok,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 pbus_start,
  output logic                 pbus_super,
  output logic [SLOT_W-1:0]    pbus_slot
);
  gate_st_e             st_q, st_d;
  logic                 start_d, super_d, ok_d;
  logic [SLOT_W-1:0]    slot_d;
  logic [WORD_BITS-1:0] rdata_d;

  always_comb begin
    unique case (st_q)
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = (accept && dec == DEC_ERR) ? ST_ERR1 : ST_IDLE;
    endcase
    start_d = accept && (dec == DEC_FWD);
    super_d = start_d && super_i;
    slot_d  = start_d ? slot : '0;
    ok_d    = accept && (dec == DEC_REG);
    rdata_d = (ok_d && !write) ? rdata_c : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pbus_start <= 1'b0;
      pbus_super <= 1'b0;
      pbus_slot  <= '0;
      resp_ok    <= 1'b0;
      rdata      <= '0;
    end else begin
      st_q       <= st_d;
      pbus_start <= start_d;
      pbus_super <= super_d;
      pbus_slot  <= slot_d;
      resp_ok    <= ok_d;
      rdata      <= rdata_d;
    end
  end

  assign ready    = (st_q != ST_ERR1);
  assign resp_err = (st_q != ST_IDLE);
endmodule

// File: rtl/periph_gate.sv
module periph_gate
  import gate_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter logic [NUM_MASTERS-1:0] MASTER_MAP = 6'b101111,
  parameter int NUM_SLOTS   = 34,
  parameter int WORD_W      = 5,
  localparam int MID_W      = $clog2(NUM_MASTERS),
  localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_to_regs,
  input  logic                 req_write,
  input  logic [MID_W-1:0]     req_master,
  input  logic                 req_prot1,
  input  logic                 req_trusted,
  input  logic [SLOT_W-1:0]    req_slot,
  input  logic [WORD_W-1:0]    req_word,
  input  logic [WORD_BITS-1:0] req_wdata,
  output logic                 req_ready,
  output logic                 resp_err,
  output logic                 resp_ok,
  output logic [WORD_BITS-1:0] resp_rdata,
  output logic                 pbus_start,
  output logic                 pbus_super,
  output logic [SLOT_W-1:0]    pbus_slot
);
  logic                   accept, cfg_we, super_c;
  logic [NUM_MASTERS-1:0] priv_en;
  logic [NUM_SLOTS-1:0]   slot_lock;
  logic [WORD_BITS-1:0]   rdata_c;
  gate_dec_e              dec;

  assign accept = req_valid && req_ready;
  assign cfg_we = accept && (dec == DEC_REG) && req_write;

  gate_cfg_regs #(
    .NUM_MASTERS(NUM_MASTERS), .MASTER_MAP(MASTER_MAP),
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .word(req_word),
    .wdata(req_wdata), .rdata(rdata_c), .priv_en(priv_en), .slot_lock(slot_lock)
  );

  gate_policy #(
    .NUM_MASTERS(NUM_MASTERS), .NUM_SLOTS(NUM_SLOTS),
    .MID_W(MID_W), .SLOT_W(SLOT_W)
  ) u_policy (
    .to_regs(req_to_regs), .master(req_master), .prot1(req_prot1),
    .trusted(req_trusted), .slot(req_slot), .priv_en(priv_en),
    .slot_lock(slot_lock), .dec(dec), .super_o(super_c)
  );

  gate_resp #(.SLOT_W(SLOT_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dec(dec), .super_i(super_c),
    .write(req_write), .slot(req_slot), .rdata_c(rdata_c),
    .ready(req_ready), .resp_err(resp_err), .resp_ok(resp_ok), .rdata(resp_rdata),
    .pbus_start(pbus_start), .pbus_super(pbus_super), .pbus_slot(pbus_slot)
  );
endmodule

// File: rtl/periph_gate_chk.sv
module periph_gate_chk #(
  parameter int NUM_MASTERS = 6,
  parameter int NUM_SLOTS   = 34,
  parameter int MID_W       = 3,
  parameter int SLOT_W      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_to_regs,
  input logic [MID_W-1:0]       req_master,
  input logic                   req_prot1,
  input logic                   req_trusted,
  input logic [SLOT_W-1:0]      req_slot,
  input logic                   resp_err,
  input logic                   resp_ok,
  input logic                   pbus_start,
  input logic                   pbus_super,
  input logic [NUM_MASTERS-1:0] priv_en,
  input logic [NUM_SLOTS-1:0]   slot_lock
);
  localparam int MPAD = 1 << MID_W;
  localparam int SPAD = 1 << SLOT_W;

  logic [MPAD-1:0] mp;
  logic [SPAD-1:0] sp;
  logic acc, pbit, lbit, periph;

  assign mp     = MPAD'(priv_en);
  assign sp     = SPAD'(slot_lock);
  assign acc    = req_valid && req_ready;
  assign pbit   = mp[req_master];
  assign lbit   = sp[req_slot];
  assign periph = acc && !req_to_regs;

  assert_user_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && !pbit) |=> !pbus_super);

  assert_super_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && pbit && (req_trusted || !lbit)) |=> (pbus_super == $past(req_prot1)));

  assert_locked_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && !req_trusted && lbit) |=> (resp_err && !pbus_start));

  assert_open_forwarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (periph && (req_trusted || !lbit)) |=> (pbus_start && !resp_err));

  assert_err_second_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_err && !req_ready) |=> (resp_err && req_ready));

  assert_stall_only_in_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> resp_err);

  assert_reg_needs_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_to_regs && !req_prot1) |=> (resp_err && !resp_ok));
endmodule

bind periph_gate periph_gate_chk #(
  .NUM_MASTERS(NUM_MASTERS), .NUM_SLOTS(NUM_SLOTS), .MID_W(MID_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_to_regs(req_to_regs), .req_master(req_master), .req_prot1(req_prot1),
  .req_trusted(req_trusted), .req_slot(req_slot), .resp_err(resp_err),
  .resp_ok(resp_ok), .pbus_start(pbus_start), .pbus_super(pbus_super),
  .priv_en(priv_en), .slot_lock(slot_lock)
);

// File: tb/periph_gate_test.sv
module periph_gate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_to_regs, req_write, req_prot1, req_trusted;
  logic [2:0]  req_master;
  logic [5:0]  req_slot;
  logic [4:0]  req_word;
  logic [31:0] req_wdata;
  logic        req_ready, resp_err, resp_ok, pbus_start, pbus_super;
  logic [31:0] resp_rdata;
  logic [5:0]  pbus_slot;

  int errors = 0;
  int checks = 0;
  logic [3:0] m_priv [6];
  logic [3:0] m_slot [34];

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_gate uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r = '0;
    if (w == 0)
      for (int m = 0; m < 6; m++) if (m != 4) r[31-4*m -: 4] = m_priv[m];
    if (w >= 16 && w <= 20)
      for (int j = 0; j < 8; j++)
        if ((w-16)*8 + j < 34) r[31-4*j -: 4] = m_slot[(w-16)*8 + j];
    return r;
  endfunction

  function automatic void model_write(input int w, input logic [31:0] d);
    if (w == 0)
      for (int m = 0; m < 6; m++) if (m != 4) m_priv[m] = d[31-4*m -: 4];
    if (w >= 16 && w <= 20)
      for (int j = 0; j < 8; j++)
        if ((w-16)*8 + j < 34) m_slot[(w-16)*8 + j] = d[31-4*j -: 4];
  endfunction

  function automatic logic exp_super(input int m, input logic p);
    return (m < 6 && m != 4) ? (m_priv[m][0] & p) : 1'b0;
  endfunction

  // Drive at a falling edge, accepted at the next rising edge, checked one cycle on
  task automatic access(input logic regs, input logic wr, input int m, input logic p,
                        input logic t, input int s, input int w, input logic [31:0] wd);
    logic err, lock;
    logic [31:0] rexp;
    string etag, stag;
    lock = (s < 34) ? m_slot[s][0] : 1'b0;
    err  = regs ? !p : (!t && lock);
    rexp = (regs && !wr) ? exp_word(w) : 32'h0;
    etag = regs ? "R7" : "R4";
    stag = (m >= 6 || m == 4) ? "R11" : (m_priv[m][0] ? "R3" : "R2");
    req_valid = 1'b1; req_to_regs = regs; req_write = wr; req_master = 3'(m);
    req_prot1 = p; req_trusted = t; req_slot = 6'(s); req_word = 5'(w); req_wdata = wd;
    @(posedge clk);
    if (regs && !err && wr) model_write(w, wd);
    @(negedge clk);
    req_valid = 1'b0;
    if (err) begin
      chk({etag, " R6 err first"}, 32'(resp_err), 32'd1);
      chk("R6 ready low", 32'(req_ready), 32'd0);
      chk({etag, " no start"}, 32'(pbus_start), 32'd0);
      @(negedge clk);
      chk("R6 err second", 32'(resp_err), 32'd1);
      chk("R6 ready high", 32'(req_ready), 32'd1);
      chk({etag, " no start 2"}, 32'(pbus_start), 32'd0);
      @(negedge clk);
      chk("R6 err cleared", 32'(resp_err), 32'd0);
    end else if (regs) begin
      chk("R8 ok", 32'(resp_ok), 32'd1);
      chk("R8 rdata", resp_rdata, rexp);
      chk("R8 no err", 32'(resp_err), 32'd0);
    end else begin
      chk("R5 start", 32'(pbus_start), 32'd1);
      chk("R5 slot", 32'(pbus_slot), 32'(s));
      chk(stag, 32'(pbus_super), 32'(exp_super(m, p)));
      chk("R5 no err", 32'(resp_err), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int m = 0; m < 6; m++) m_priv[m] = '0;
    for (int k = 0; k < 34; k++) m_slot[k] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_to_regs = 1'b0; req_write = 1'b0;
    req_master = '0; req_prot1 = 1'b0; req_trusted = 1'b0; req_slot = '0;
    req_word = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 err", 32'(resp_err), 32'd0);
    chk("R1 ok", 32'(resp_ok), 32'd0);
    chk("R1 start", 32'(pbus_start), 32'd0);
    access(1, 0, 0, 1, 1, 0, 0, 0);
    access(1, 0, 0, 1, 1, 0, 16, 0);
    access(1, 0, 0, 1, 1, 0, 20, 0);
    // R1 demoted out of reset, R2
    access(0, 0, 0, 1, 0, 3, 0, 0);
    // R7 unprivileged write ignored, checked by read back
    access(1, 1, 2, 0, 1, 0, 0, 32'hFFFF_FFFF);
    access(1, 0, 2, 1, 1, 0, 0, 0);
    // R9 unimplemented bits
    access(1, 1, 0, 1, 1, 0, 0, 32'hFFFF_FFFF);
    access(1, 0, 0, 1, 1, 0, 0, 0);
    chk("R9 priv mask", resp_rdata, 32'hFFFF_0F00);
    access(1, 1, 0, 1, 1, 0, 20, 32'hFFFF_FFFF);
    access(1, 0, 0, 1, 1, 0, 20, 0);
    chk("R9 lock tail mask", resp_rdata, 32'hFF00_0000);
    access(1, 1, 0, 1, 1, 0, 5, 32'hFFFF_FFFF);
    access(1, 0, 0, 1, 1, 0, 5, 0);
    chk("R9 hole", resp_rdata, 32'h0);
    // R11 master 4 and IDs 6,7 stay user; R3 others follow
    access(0, 0, 4, 1, 1, 1, 0, 0);
    access(0, 0, 7, 1, 1, 1, 0, 0);
    access(0, 0, 5, 1, 1, 1, 0, 0);
    // R4 locked slot 33, R11 slot 40 open
    access(0, 0, 1, 1, 0, 33, 0, 0);
    access(0, 0, 1, 1, 1, 33, 0, 0);
    access(0, 0, 1, 1, 0, 40, 0, 0);
    // R10 upper bits stored but inert: slot 8 field 0xE
    access(1, 1, 0, 1, 1, 0, 17, 32'hE000_0000);
    access(1, 0, 0, 1, 1, 0, 17, 0);
    chk("R10 readback", resp_rdata, 32'hE000_0000);
    access(0, 0, 1, 0, 0, 8, 0, 0);
    chk("R10 slot open", 32'(pbus_start), 32'd1);
    access(1, 1, 0, 1, 1, 0, 0, 32'hEEEE_0E00);
    access(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R10 priv inert", 32'(pbus_super), 32'd0);
    // R6 failing access accepted in the second error cycle
    req_valid = 1'b1; req_to_regs = 1'b1; req_prot1 = 1'b0; req_write = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R6 b2b first", 32'({resp_err, req_ready}), 32'b10);
    @(negedge clk);
    chk("R6 b2b second", 32'({resp_err, req_ready}), 32'b11);
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R6 b2b restart", 32'({resp_err, req_ready}), 32'b10);
    @(negedge clk);
    chk("R6 b2b restart second", 32'({resp_err, req_ready}), 32'b11);
    @(negedge clk);
    chk("R6 b2b done", 32'(resp_err), 32'd0);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      int kind = int'($urandom % 8);
      int wsel = int'($urandom % 8);
      int w = (wsel == 0) ? 0 : (wsel < 6) ? 15 + wsel : int'($urandom % 32);
      logic [31:0] d = $urandom;
      if (kind < 2)      access(1, 1, int'($urandom % 8), ($urandom % 5) != 0, 1, 0, w, d);
      else if (kind < 4) access(1, 0, int'($urandom % 8), ($urandom % 5) != 0, 1, 0, w, 0);
      else access(0, 0, int'($urandom % 8), 1'($urandom), 1'($urandom),
                  int'($urandom % 64), 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule